// File: doc/BRIEF.md
# Clock Gate Controller with Hardware/Software Ownership

This block controls the enable of one gated clock branch. A small control register chooses who owns the gate. Software can own it and switch it with an enable bit, or a hardware request input can drive it directly. Turn-on takes effect on the next clock. Turn-off can be held back by a programmable hysteresis, with a short or a long delay, so that a request that drops briefly does not toggle the branch. A request that returns during the delay cancels the pending turn-off.

The gated enable output is launched from the falling edge of the source clock. It is stable for the whole high phase, so a downstream gating cell never sees a runt pulse. A read-only status bit shows the real gate state through a short synchroniser chain. Software that polls it after a change therefore sees the change a few cycles late.

A build parameter can mark the gate as never-disable. Under software ownership the gate then stays on, and the stored enable bit reads back as 0. The control register stores the enable bit only while software owns the gate. Under hardware ownership it always reads 0.

Top module: `clk_gate_ctrl`

## Requirements
- R1: After reset, `rdata_o` is 0 (hardware ownership, enable off, hysteresis off, status 0) and `gate_en_o` is 0.
- R2: With ownership bit 1 of the control word set to 1 (software), the gate follows enable bit 0, and `hw_req_i` has no effect on `gate_en_o`.
- R3: With ownership bit 1 at 0 (hardware), the gate follows `hw_req_i`. The stored enable bit reads back 0 in `rdata_o[0]` whatever value was written.
- R4: With parameter NEVER_OFF=1 and software ownership, `gate_en_o` stays 1 and `rdata_o[0]` reads 0 even when enable is written as 1 or 0.
- R5: Turn-on is never delayed by hysteresis. A request that rises is seen on `gate_en_o` at the falling edge that follows the next rising edge.
- R6: With hysteresis-enable bit 2 at 0, `gate_en_o` goes low at the falling edge that follows the first rising edge at which the request is low.
- R7: With bit 2 at 1, turn-off waits HYST_LO extra cycles when hysteresis-length bit 3 is 0, and HYST_HI extra cycles when it is 1 (defaults 8 and 64).
- R8: A request that returns high during the turn-off delay cancels it. The next drop starts a full new delay.
- R9: Status bit 4 of `rdata_o` equals `gate_en_o` as it was SYNC_STAGES rising edges earlier (default 3).
- R10: `gate_en_o` changes only at a falling edge of `clk_i`, never while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Control register write strobe |
| wdata_i | input | 4 | Write data: bit0 enable, bit1 software ownership, bit2 hysteresis enable, bit3 long hysteresis |
| hw_req_i | input | 1 | Hardware request for the clock |
| rdata_o | output | 5 | Readback: stored control bits 3..0, status in bit 4 |
| gate_en_o | output | 1 | Glitch-free gated clock enable |

## Verification
Assertions check on every cycle that the enable bit is clear under hardware ownership and under never-disable, and that a high request turns the gate on in the next cycle. They also check that a low request with hysteresis off turns it off in the next cycle, that the delay counter stays inside its bound, and that the status bit is the gate output delayed by the synchroniser depth. Only the bench scenarios can show the exact lengths of the short and long turn-off delays, the cancel-and-restart of a delay, and that software ownership hides the hardware request. They also show that the output never moves while the clock is high.

// File: rtl/cg_pkg.sv
`timescale 1ns/1ps
package cg_pkg;
  localparam int unsigned CTRL_W = 4;
  localparam int unsigned RD_W   = CTRL_W + 1;

  typedef struct packed {
    logic hyst_long;
    logic hyst_on;
    logic own_sw;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/cg_regs.sv
`timescale 1ns/1ps
module cg_regs
  import cg_pkg::*;
#(
  parameter bit NEVER_OFF = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output ctrl_t             ctrl_o
);
  ctrl_t wr_c, ctrl_q;

  always_comb begin
    wr_c = ctrl_t'(wdata_i);
    // enable bit only retained when software owns a disableable gate
    wr_c.en = wr_c.en & wr_c.own_sw & ~NEVER_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (wr_i) ctrl_q <= wr_c;
  end

  assign ctrl_o = ctrl_q;

  p_en_clear_hw_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.own_sw |-> !ctrl_q.en)
    else $error("R3: enable bit set under hardware ownership");
endmodule

// File: rtl/cg_hyst.sv
`timescale 1ns/1ps
module cg_hyst #(
  parameter int unsigned HYST_LO = 8,
  parameter int unsigned HYST_HI = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hyst_on_i,
  input  logic hyst_long_i,
  output logic on_o
);
  localparam int unsigned CW = $clog2(HYST_HI + 1);

  logic [CW-1:0] cnt_q, limit;
  logic          on_q;

  assign limit = hyst_long_i ? CW'(HYST_HI) : CW'(HYST_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q  <= 1'b0;
      cnt_q <= '0;
    end else if (req_i) begin
      on_q  <= 1'b1;
      cnt_q <= '0;
    end else if (on_q) begin
      if (!hyst_on_i || cnt_q >= limit) begin
        on_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign on_o = on_q;

  p_turn_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> on_q)
    else $error("R5: turn-on delayed");

  p_off_direct_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i && !hyst_on_i) |=> !on_q)
    else $error("R6: turn-off delayed without hysteresis");

  p_cnt_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(HYST_HI))
    else $error("R7: delay counter out of range");
endmodule

// File: rtl/cg_gate.sv
`timescale 1ns/1ps
module cg_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  output logic gate_en_o
);
  // launched in the low phase so the enable is steady across the high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_en_o <= 1'b0;
    else         gate_en_o <= on_i;
  end
endmodule

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[i] <= 1'b0;
        else         q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q[i] <= 1'b0;
        else         q[i] <= q[i-1];
      end
    end
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl
  import cg_pkg::*;
#(
  parameter bit          NEVER_OFF   = 1'b0,
  parameter int unsigned HYST_LO     = 8,
  parameter int unsigned HYST_HI     = 64,
  parameter int unsigned SYNC_STAGES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              hw_req_i,
  output logic [RD_W-1:0]   rdata_o,
  output logic              gate_en_o
);
  ctrl_t ctrl;
  logic  req, on, status;

  cg_regs #(.NEVER_OFF(NEVER_OFF)) u_regs (
    .clk_i, .rst_ni, .wr_i, .wdata_i, .ctrl_o(ctrl)
  );

  assign req = ctrl.own_sw ? (ctrl.en | NEVER_OFF) : hw_req_i;

  cg_hyst #(.HYST_LO(HYST_LO), .HYST_HI(HYST_HI)) u_hyst (
    .clk_i, .rst_ni, .req_i(req), .hyst_on_i(ctrl.hyst_on),
    .hyst_long_i(ctrl.hyst_long), .on_o(on)
  );

  cg_gate u_gate (.clk_i, .rst_ni, .on_i(on), .gate_en_o);

  cg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(gate_en_o), .q_o(status)
  );

  assign rdata_o = {status, ctrl};

  p_status_lag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status == $past(gate_en_o, SYNC_STAGES))
    else $error("R9: status does not track delayed gate");

  if (NEVER_OFF) begin : g_noff_chk
    p_never_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl.own_sw |=> (on && !ctrl.en))
      else $error("R4: never-disable gate turned off or enable stored");
  end
endmodule

// File: tb/sim_clk_gate_ctrl.sv
`timescale 1ns/1ps
module sim_clk_gate_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0, hw_req = 1'b0;
  logic [3:0] wdata = '0;
  logic [4:0] rdata, rdata1;
  logic       gate, gate1;
  int         n_chk = 0, n_fail = 0, hi_moves = 0;
  bit         done = 1'b0;

  localparam int LO = 8, HI = 64, SYNC = 3;

  always #5 clk = ~clk;

  clk_gate_ctrl u0 (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata),
                    .hw_req_i(hw_req), .rdata_o(rdata), .gate_en_o(gate));
  clk_gate_ctrl #(.NEVER_OFF(1'b1)) u1 (.clk_i(clk), .rst_ni(rst_n), .wr_i(wr),
                    .wdata_i(wdata), .hw_req_i(hw_req), .rdata_o(rdata1), .gate_en_o(gate1));

  always @(gate) if (clk && rst_n) hi_moves++;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr_ctrl(logic [3:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic t_reset;
    step(1);
    chk("R1 rdata", rdata, 0);
    chk("R1 gate", gate, 0);
  endtask

  task automatic t_hw_own;
    hw_req = 1'b1; step(1);
    chk("R3 gate follows hw req high", gate, 1);
    wr_ctrl(4'b0001); step(1);
    chk("R3 enable reads 0 under hw", rdata[0], 0);
    hw_req = 1'b0; step(1);
    chk("R6 hw drop without hysteresis", gate, 0);
  endtask

  task automatic t_sw_own;
    wr_ctrl(4'b0011); step(1);
    chk("R5 sw turn-on next cycle", gate, 1);
    chk("R2 enable stored", rdata[0], 1);
    hw_req = 1'b1;
    wr_ctrl(4'b0010); step(1);
    chk("R2 hw req ignored under sw", gate, 0);
    hw_req = 1'b0; step(SYNC + 3);
  endtask

  task automatic t_status;
    wr_ctrl(4'b0011);
    step(1);      chk("R9 gate up", gate, 1);
    step(2);      chk("R9 status still low", rdata[4], 0);
    step(1);      chk("R9 status high", rdata[4], 1);
    wr_ctrl(4'b0010);
    step(SYNC);   chk("R9 status still high", rdata[4], 1);
    step(1);      chk("R9 status low", rdata[4], 0);
  endtask

  task automatic t_hyst(bit long_d);
    int d = long_d ? HI : LO;
    wr_ctrl({long_d, 3'b111}); step(1);
    chk("R7 on before drop", gate, 1);
    wr_ctrl({long_d, 3'b110});
    step(d);  chk(long_d ? "R7 high delay held" : "R7 low delay held", gate, 1);
    step(1);  chk(long_d ? "R7 high delay expired" : "R7 low delay expired", gate, 0);
  endtask

  task automatic t_cancel;
    wr_ctrl(4'b0100);
    hw_req = 1'b1; step(1);
    hw_req = 1'b0; step(4);
    hw_req = 1'b1; step(LO + 4);
    chk("R8 cancelled turn-off", gate, 1);
    hw_req = 1'b0; step(LO);
    chk("R8 fresh delay held", gate, 1);
    step(1);
    chk("R8 fresh delay expired", gate, 0);
  endtask

  task automatic t_never_off;
    wr_ctrl(4'b0010); step(1);
    chk("R4 gate on with enable 0", gate1, 1);
    chk("R4 enable reads 0", rdata1[0], 0);
    wr_ctrl(4'b0011); step(1);
    chk("R4 enable still reads 0", rdata1[0], 0);
    chk("R4 gate still on", gate1, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_hw_own;
    t_sw_own;
    t_status;
    t_hyst(1'b0);
    t_hyst(1'b1);
    t_cancel;
    t_never_off;
    chk("R10 gate moved while clock high", hi_moves, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule